// File: doc/BRIEF.md
# Real-time clock mode register with interrupt gating

This block holds the second mode byte of a real-time clock and gates three clock events (periodic, alarm and update-ended) into one shared interrupt flag. Software reaches it through a byte-wide port with a one-bit index. Index 0 is the mode byte: an update-inhibit bit, three interrupt enables and three calendar mode bits. Index 1 is a read-to-clear status byte that holds the latched event flags and the shared interrupt flag.

A one-second tick starts a timed update cycle while updates are allowed. Setting the inhibit bit stops further cycles and aborts a cycle that is running. The periodic and alarm events arrive as single-cycle pulses. The update-ended event comes from the end of an update cycle that ran to completion. The block has two synchronous active-low resets. The full reset clears the enables, the flags and the update sequencer. The clock-only reset does the same but never touches the inhibit bit or the mode bits.

Top module: `rtc_mode_irq_reg`

## Requirements
- R1: A write at index 0 stores the byte. A read at index 0 returns it with bit 3 forced to 0. The bit map is: bit 7 inhibit, bit 6 periodic enable, bit 5 alarm enable, bit 4 update-ended enable, bit 3 reserved, bit 2 date mode, bit 1 hour-format select, bit 0 daylight-saving enable. `updEnable` is the inverse of bit 7, and `dateMode`, `hourMode` and `dstEnable` mirror bits 2, 1 and 0.
- R2: A read at index 1 returns interrupt flag in bit 7, periodic flag in bit 6, alarm flag in bit 5, update-ended flag in bit 4, and zeros below. Writes at index 1 change nothing. `rdData` is 0 whenever `regRd` is low.
- R3: The full reset clears bits 6 to 4, all flags, the interrupt flag and any update cycle. Bits 7 and 2 to 0 keep their prior values.
- R4: The clock-only reset clears the enables, the flags, the interrupt flag and any update cycle. It leaves bits 7 and 2 to 0 unchanged. Writes made while either reset is active are ignored.
- R5: A tick sampled while the effective inhibit bit is 0 and no cycle is running starts an update cycle. The effective bit counts a write in the same cycle. `updBusy` is high for UPD_CYCLES cycles, and the update-ended flag sets at the edge that ends it. A tick while inhibited or busy does nothing.
- R6: Writing the mode byte with bit 7 set while a cycle runs ends it at that edge. `updAbort` pulses for one cycle, and the update-ended flag does not set.
- R7: An event pulse sets its flag, which stays set until a status read. The read clears the flags at its own edge, but an event in the same cycle keeps its flag set.
- R8: A periodic or alarm event that sets its flag while its enable is 1 sets the interrupt flag at the same edge. The enable counted here includes a write in that cycle. An event during a status read counts as a new transition.
- R9: Writing an enable from 0 to 1 while its flag is already 1 sets the interrupt flag at that edge.
- R10: The interrupt flag stays set until a status read. Clearing an enable does not clear it, and an event whose enable is 0 does not set it.
- R11: The update-ended flag and its enable follow the same rules as R7 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Full reset, synchronous, active low |
| rtcRstN | input | 1 | Clock-only reset, synchronous, active low |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (index 1 read clears status) |
| regSel | input | 1 | Index: 0 mode byte, 1 status byte |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational, 0 when not reading |
| secTick | input | 1 | One-second tick pulse |
| perEvt | input | 1 | Periodic event pulse |
| almEvt | input | 1 | Alarm match pulse |
| updEnable | output | 1 | Update cycles allowed (inhibit bit clear) |
| updBusy | output | 1 | Update cycle in progress |
| updAbort | output | 1 | One-cycle pulse after an aborted update cycle |
| perFlag | output | 1 | Latched periodic flag |
| almFlag | output | 1 | Latched alarm flag |
| updFlag | output | 1 | Latched update-ended flag |
| irqFlag | output | 1 | Shared interrupt flag |
| dateMode | output | 1 | Date encoding mode bit |
| hourMode | output | 1 | Hour format select bit |
| dstEnable | output | 1 | Daylight-saving enable bit |

## Verification
A wrong enable or flag bit shows on `irqFlag` at the same edge as the event that should have been gated. It also shows on the next status read, which the bench performs after every stimulus. A wrong sequencer count moves the rise of `updFlag` and the fall of `updBusy` away from the edge that comes UPD_CYCLES cycles after the tick, and the bench checks that edge and every cycle before it. A reset that reaches the wrong bits appears on the first mode-byte read after the reset.

// File: rtl/rtc_mode_pkg.sv
package rtc_mode_pkg;
  localparam int NUM_SRC    = 3;   // 0 periodic, 1 alarm, 2 update-ended
  localparam int EN_TOP_BIT = 6;   // enable of source i sits at bit EN_TOP_BIT-i
  localparam int INH_BIT    = 7;
  localparam logic CTRL_IDX = 1'b0;
  localparam logic STAT_IDX = 1'b1;

  typedef struct packed {
    logic ctlWr;    // mode byte write accepted this cycle
    logic statRd;   // status read (clears flags)
    logic updDone;  // update cycle completes at this edge
  } strobes_t;
endpackage

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_mode_pkg::*;
#(
  parameter int UPD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rtcRstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       regSel,
  input  logic       wrInhibit,
  input  logic       secTick,
  input  logic       inhibitQ,
  output strobes_t   strb,
  output logic       updBusy,
  output logic       updAbort
);
  localparam int CNT_W = $clog2(UPD_CYCLES + 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             abortQ;
  logic             ctlWr;
  logic             inhibitEff;
  logic             abortNow;
  logic             doneNow;
  logic             startNow;

  assign ctlWr      = regWr && (regSel == CTRL_IDX);
  assign inhibitEff = ctlWr ? wrInhibit : inhibitQ;
  assign abortNow   = ctlWr && wrInhibit && busyQ;
  assign doneNow    = busyQ && (cntQ == '0) && !abortNow;
  assign startNow   = secTick && !inhibitEff && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN || !rtcRstN) begin
      busyQ  <= 1'b0;
      cntQ   <= '0;
      abortQ <= 1'b0;
    end else begin
      abortQ <= abortNow;
      if (abortNow) begin
        busyQ <= 1'b0;
      end else if (startNow) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_W'(UPD_CYCLES - 1);
      end else if (busyQ) begin
        if (cntQ == '0) busyQ <= 1'b0;
        else            cntQ  <= cntQ - 1'b1;
      end
    end
  end

  always_comb begin
    strb.ctlWr   = ctlWr;
    strb.statRd  = regRd && (regSel == STAT_IDX);
    strb.updDone = doneNow;
  end

  assign updBusy  = busyQ;
  assign updAbort = abortQ;
endmodule

// File: rtl/rtc_mode_path.sv
module rtc_mode_path
  import rtc_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rtcRstN,
  input  strobes_t   strb,
  input  logic [7:0] wrData,
  input  logic       perEvt,
  input  logic       almEvt,
  output logic       inhibitQ,
  output logic [7:0] ctlByte,
  output logic [7:0] statByte,
  output logic [NUM_SRC-1:0] flags,
  output logic       irqFlag
);
  logic [2:0]         modeQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] flagQ;
  logic               irqQ;
  logic [NUM_SRC-1:0] evtVec;
  logic [NUM_SRC-1:0] enNew;
  logic [NUM_SRC-1:0] flagNext;
  logic [NUM_SRC-1:0] irqSrc;
  logic               irqNext;

  assign evtVec = {strb.updDone, almEvt, perEvt};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic wrBit;
    logic enRise;
    assign wrBit       = wrData[EN_TOP_BIT - i];
    assign enNew[i]    = strb.ctlWr ? wrBit : enQ[i];
    assign enRise      = strb.ctlWr && wrBit && !enQ[i];
    assign irqSrc[i]   = (evtVec[i] && (!flagQ[i] || strb.statRd) && enNew[i])
                       || (enRise && flagQ[i] && !strb.statRd);
    assign flagNext[i] = evtVec[i] || (flagQ[i] && !strb.statRd);
  end

  assign irqNext = (|irqSrc) || (irqQ && !strb.statRd);

  always_ff @(posedge clk) begin
    if (!rstN || !rtcRstN) begin
      enQ   <= '0;
      flagQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      enQ   <= enNew;
      flagQ <= flagNext;
      irqQ  <= irqNext;
    end
  end

  // inhibit and mode bits: no reset of either kind reaches them
  always_ff @(posedge clk) begin
    if (rstN && rtcRstN && strb.ctlWr) begin
      inhibitQ <= wrData[INH_BIT];
      modeQ    <= wrData[2:0];
    end
  end

  assign ctlByte  = {inhibitQ, enQ[0], enQ[1], enQ[2], 1'b0, modeQ};
  assign statByte = {irqQ, flagQ[0], flagQ[1], flagQ[2], 4'b0000};
  assign flags    = flagQ;
  assign irqFlag  = irqQ;
endmodule

// File: rtl/rtc_mode_irq_reg.sv
module rtc_mode_irq_reg
  import rtc_mode_pkg::*;
#(
  parameter int UPD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rtcRstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       secTick,
  input  logic       perEvt,
  input  logic       almEvt,
  output logic       updEnable,
  output logic       updBusy,
  output logic       updAbort,
  output logic       perFlag,
  output logic       almFlag,
  output logic       updFlag,
  output logic       irqFlag,
  output logic       dateMode,
  output logic       hourMode,
  output logic       dstEnable
);
  strobes_t           strb;
  logic               inhibitQ;
  logic [7:0]         ctlByte;
  logic [7:0]         statByte;
  logic [NUM_SRC-1:0] flags;

  rtc_upd_ctrl #(.UPD_CYCLES(UPD_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .rtcRstN(rtcRstN),
    .regWr(regWr), .regRd(regRd), .regSel(regSel),
    .wrInhibit(wrData[INH_BIT]), .secTick(secTick), .inhibitQ(inhibitQ),
    .strb(strb), .updBusy(updBusy), .updAbort(updAbort)
  );

  rtc_mode_path i_path (
    .clk(clk), .rstN(rstN), .rtcRstN(rtcRstN), .strb(strb),
    .wrData(wrData), .perEvt(perEvt), .almEvt(almEvt),
    .inhibitQ(inhibitQ), .ctlByte(ctlByte), .statByte(statByte),
    .flags(flags), .irqFlag(irqFlag)
  );

  assign rdData    = !regRd ? 8'h00 : (regSel == STAT_IDX) ? statByte : ctlByte;
  assign updEnable = !inhibitQ;
  assign perFlag   = flags[0];
  assign almFlag   = flags[1];
  assign updFlag   = flags[2];
  assign dateMode  = ctlByte[2];
  assign hourMode  = ctlByte[1];
  assign dstEnable = ctlByte[0];
endmodule

// File: rtl/rtc_mode_irq_chk.sv
module rtc_mode_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rtcRstN,
  input logic [7:0] ctlByte,
  input logic       regRd,
  input logic       regSel,
  input logic       updEnable,
  input logic       updBusy,
  input logic       updAbort,
  input logic       perFlag,
  input logic       almFlag,
  input logic       irqFlag
);
  assert_inhibit_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rtcRstN |=> $stable(updEnable));

  assert_rtc_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rtcRstN |=> (ctlByte[6:4] == 3'b000) && !irqFlag && !perFlag && !almFlag);

  assert_no_start_R5: assert property (@(posedge clk) disable iff (!rstN || !rtcRstN)
    (!updEnable && !updBusy) |=> (!updBusy || updEnable));

  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    updAbort |-> (!updBusy && !updEnable));

  assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rstN || !rtcRstN)
    ($rose(perFlag) && ctlByte[6]) |-> irqFlag);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rstN || !rtcRstN)
    (irqFlag && !(regRd && regSel)) |=> irqFlag);
endmodule

bind rtc_mode_irq_reg rtc_mode_irq_chk i_chk (
  .clk(clk), .rstN(rstN), .rtcRstN(rtcRstN), .ctlByte(ctlByte),
  .regRd(regRd), .regSel(regSel), .updEnable(updEnable), .updBusy(updBusy),
  .updAbort(updAbort), .perFlag(perFlag), .almFlag(almFlag), .irqFlag(irqFlag)
);

// File: tb/test_rtc_mode_irq_reg.sv
module test_rtc_mode_irq_reg;
  localparam int UPD_N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, rtcRstN = 1'b1;
  logic regWr = 1'b0, regRd = 1'b0, regSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic secTick = 1'b0, perEvt = 1'b0, almEvt = 1'b0;
  logic updEnable, updBusy, updAbort, perFlag, almFlag, updFlag, irqFlag;
  logic dateMode, hourMode, dstEnable;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_mode_irq_reg #(.UPD_CYCLES(UPD_N)) i_rtc_mode_irq_reg (
    .clk(clk), .rstN(rstN), .rtcRstN(rtcRstN), .regWr(regWr), .regRd(regRd),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .secTick(secTick),
    .perEvt(perEvt), .almEvt(almEvt), .updEnable(updEnable), .updBusy(updBusy),
    .updAbort(updAbort), .perFlag(perFlag), .almFlag(almFlag), .updFlag(updFlag),
    .irqFlag(irqFlag), .dateMode(dateMode), .hourMode(hourMode), .dstEnable(dstEnable)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrIdx(input logic sel, input logic [7:0] b);
    regWr = 1'b1; regSel = sel; wrData = b;
    cycle();
    regWr = 1'b0; regSel = 1'b0; wrData = 8'h00;
  endtask

  task automatic rdIdx(input logic sel, output logic [7:0] b);
    regRd = 1'b1; regSel = sel;
    #1 b = rdData;
    cycle();
    regRd = 1'b0; regSel = 1'b0;
  endtask

  // fire one event source: 0 periodic, 1 alarm, 2 tick-driven update cycle
  task automatic fire(input int s);
    if (s == 0) begin perEvt = 1'b1; cycle(); perEvt = 1'b0; end
    else if (s == 1) begin almEvt = 1'b1; cycle(); almEvt = 1'b0; end
    else begin
      secTick = 1'b1; cycle(); secTick = 1'b0;
      chk("R5 busy after tick", updBusy, 1);
      for (int j = 1; j < UPD_N; j++) begin
        cycle();
        chk("R5 busy held", updBusy, 1);
        chk("R5 no early flag", updFlag, 0);
      end
      cycle();
      chk("R5 busy end", updBusy, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb, st;
    @(negedge clk); cycle(); cycle();
    rstN = 1'b1;
    cycle();
    // R3 reset state
    rdIdx(1'b0, rb);
    chk("R3 enables cleared", rb & 8'h78, 8'h00);
    rdIdx(1'b1, st);
    chk("R3 status cleared", st, 8'h00);
    chk("R3 irq", irqFlag, 0);
    chk("R3 busy", updBusy, 0);
    chk("R3 abort", updAbort, 0);
    chk("R2 idle read zero", rdData, 0);

    // R1 sweep of all mode bytes
    for (int b = 0; b < 256; b++) begin
      wrIdx(1'b0, 8'(b));
      rdIdx(1'b0, rb);
      chk("R1 readback", rb, 8'(b) & 8'hF7);
      chk("R1 outputs", {updEnable, dateMode, hourMode, dstEnable},
          {~b[7], 3'(b & 7)});
    end
    wrIdx(1'b0, 8'h80);
    rdIdx(1'b1, st);
    chk("R10 no irq from writes alone", st, 8'h00);

    // R7 R8 R9 R11 per source, with and without enable
    for (int s = 0; s < 3; s++) begin
      for (int en = 0; en < 2; en++) begin
        logic [7:0] ctl, enBit;
        string tag;
        tag = (s == 2) ? "R11" : ((en == 1) ? "R8" : "R10");
        enBit = 8'h40 >> s;
        ctl = (s == 2) ? 8'h00 : 8'h80;
        if (en == 1) ctl = ctl | enBit;
        rdIdx(1'b1, st);
        wrIdx(1'b0, ctl);
        fire(s);
        chk({tag, " irq after event"}, irqFlag, 32'(en));
        chk("R7 flag latched", {perFlag, almFlag, updFlag}, 3'b100 >> s);
        cycle();
        chk("R7 flag held", {perFlag, almFlag, updFlag}, 3'b100 >> s);
        if (en == 0) begin
          wrIdx(1'b0, ctl | enBit);
          chk((s == 2) ? "R11 late enable" : "R9 late enable", irqFlag, 1);
        end
        rdIdx(1'b1, st);
        chk("R2 status layout", st, 8'h80 | enBit);
        rdIdx(1'b1, st);
        chk("R7 read cleared", st, 8'h00);
      end
    end

    // R5 tick while inhibited, and tick with same-cycle inhibit write
    wrIdx(1'b0, 8'h80);
    secTick = 1'b1; cycle(); secTick = 1'b0;
    chk("R5 inhibited no start", updBusy, 0);
    wrIdx(1'b0, 8'h00);
    regWr = 1'b1; wrData = 8'h80; secTick = 1'b1;
    cycle();
    regWr = 1'b0; wrData = 8'h00; secTick = 1'b0;
    chk("R5 same-cycle inhibit", updBusy, 0);
    repeat (UPD_N + 1) cycle();
    rdIdx(1'b1, st);
    chk("R5 no update flag", st, 8'h00);

    // R6 abort
    wrIdx(1'b0, 8'h10);
    secTick = 1'b1; cycle(); secTick = 1'b0;
    cycle();
    chk("R6 busy before abort", updBusy, 1);
    wrIdx(1'b0, 8'h90);
    chk("R6 busy dropped", updBusy, 0);
    chk("R6 abort pulse", updAbort, 1);
    chk("R6 inhibited", updEnable, 0);
    cycle();
    chk("R6 abort one cycle", updAbort, 0);
    repeat (UPD_N) cycle();
    rdIdx(1'b1, st);
    chk("R6 no update flag", st, 8'h00);

    // R8 enable written in the same cycle as the event
    regWr = 1'b1; regSel = 1'b0; wrData = 8'hC0; perEvt = 1'b1;
    cycle();
    regWr = 1'b0; wrData = 8'h00; perEvt = 1'b0;
    chk("R8 same-cycle enable", irqFlag, 1);
    // R7 R8 event during status read wins
    regRd = 1'b1; regSel = 1'b1; perEvt = 1'b1;
    #1 st = rdData;
    cycle();
    regRd = 1'b0; regSel = 1'b0; perEvt = 1'b0;
    chk("R7 read value", st, 8'hC0);
    chk("R7 event beats clear", perFlag, 1);
    chk("R8 event during read", irqFlag, 1);
    rdIdx(1'b1, st);

    // R10 disabling does not clear irq
    wrIdx(1'b0, 8'hA0);
    almEvt = 1'b1; cycle(); almEvt = 1'b0;
    chk("R8 alarm irq", irqFlag, 1);
    wrIdx(1'b0, 8'h80);
    chk("R10 irq kept after disable", irqFlag, 1);
    rdIdx(1'b1, st);
    chk("R10 read value", st, 8'hA0);
    chk("R10 read clears irq", irqFlag, 0);

    // R2 status write ignored
    perEvt = 1'b1; cycle(); perEvt = 1'b0;
    wrIdx(1'b1, 8'hFF);
    rdIdx(1'b0, rb);
    chk("R2 status write leaves mode", rb, 8'h80);
    rdIdx(1'b1, st);
    chk("R2 status write ignored", st, 8'h40);

    // R4 clock-only reset
    wrIdx(1'b0, 8'hF5);
    perEvt = 1'b1; cycle(); perEvt = 1'b0;
    chk("R4 pre irq", irqFlag, 1);
    rtcRstN = 1'b0;
    regWr = 1'b1; regSel = 1'b0; wrData = 8'h02;
    cycle(); cycle();
    regWr = 1'b0; wrData = 8'h00; rtcRstN = 1'b1;
    cycle();
    rdIdx(1'b0, rb);
    chk("R4 mode kept, enables cleared", rb, 8'h85);
    rdIdx(1'b1, st);
    chk("R4 status cleared", st, 8'h00);
    chk("R4 inhibit kept", updEnable, 0);

    // R3 full reset keeps bits 7 and 2..0
    wrIdx(1'b0, 8'h73);
    almEvt = 1'b1; cycle(); almEvt = 1'b0;
    rstN = 1'b0;
    regWr = 1'b1; regSel = 1'b0; wrData = 8'h84;
    cycle(); cycle();
    regWr = 1'b0; wrData = 8'h00; rstN = 1'b1;
    cycle();
    rdIdx(1'b0, rb);
    chk("R3 hold bits", rb, 8'h03);
    rdIdx(1'b1, st);
    chk("R3 flags cleared", st, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule